// File: doc/BRIEF.md
# Capture-Compare Timer with One-Shot Output

This block is a single time base paired with an output-compare stage. The counter is either one 16-bit counter or a cascaded 32-bit counter. It advances on a count enable chosen from the core clock or from one of several slow or external sources. When the count reaches a programmed period it returns to zero and raises a rollover event. A compare stage watches the count. On a match it toggles the output pin, in either free-running or one-shot fashion.

Software drives the block through a narrow write port. The port holds a control word, the period, the compare value and a counter preset. A strobe register arms and disarms one-shot operation. Interrupts pass through a programmable postscaler. A separate trigger pulse reports either every compare match or every rollover. Output changes can be held back and released at the next rollover, so the pin stays aligned to the time base.

Top module: `ccomp_timer`

## Requirements
- R1: In 16-bit mode (control bit 1 = 0), the counter steps once per selected tick from 0 up to and including the low period value, then returns to 0. Each such wrap produces one rollover event, so a period P gives one event every P+1 ticks.
- R2: In 32-bit mode (control bit 1 = 1), the rollover happens only when the full 32-bit count equals the 32-bit period. The low half passing FFFFh carries into the high half and never clears the counter. The counter keeps counting even when the high half equals the high period and the low half was preset above the low period.
- R3: In one-shot mode (control bit 5 = 1), the counter runs only while armed. Each arming gives at most one compare event, meaning one pin toggle and one compare interrupt source event. A compare value of 0000h behaves the same way. While disarmed, no compare event occurs. The one-shot disarms itself at the period match.
- R4: Writing address 7 with data bit 0 set arms the one-shot and restarts the count from 0, including when it is already armed (retrigger). Data bit 1 set disarms it and zeroes the count, and it wins if both bits are set. Both strobes act only in one-shot mode.
- R5: With output synchronisation on (control bit 6 = 1), a pending toggle is applied only on the cycle the rollover event is raised. This holds from the very first period after enable.
- R6: With the special event select on (control bit 7 = 1), the trigger output pulses once for every compare event, whatever the postscaler value. With it off, the trigger output pulses once per rollover.
- R7: The interrupt source is the rollover event when control bit 12 = 0 and the compare event when it is 1. A postscaler value N in control bits 11:8 gives one interrupt pulse per N+1 source events.
- R8: The clock select in control bits 4:2 works as follows. Code 000 counts every core clock. Codes 010, 011, 101, 110 and 111 count rising edges of the slow oscillator, low-power, logic-cell, external A and external B inputs respectively. Codes 001 and 100 never count.
- R9: After reset, and within two clock edges of writing a control word with bit 0 = 0, the count is 0, the output pin is low and no interrupt pulses. On re-enable the counter starts from 0.
- R10: In free-running mode (control bit 5 = 0) without synchronisation, every compare match toggles the output pin on the following clock edge.
- R11: Register addresses are: 0 control, 1 and 2 period low and high, 3 and 4 compare low and high, 5 and 6 counter preset low and high, 7 strobe. A write takes effect at the next clock edge. The high preset is only loaded in 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| slow_osc_in | input | 1 | Slow oscillator count source |
| lowpwr_in | input | 1 | Low-power slow count source |
| logic_cell_in | input | 1 | Logic-cell count source |
| ext_a_in | input | 1 | External count source A |
| ext_b_in | input | 1 | External count source B |
| cmp_out | output | 1 | Compare output pin |
| irq_pulse | output | 1 | One-cycle interrupt pulse after the postscaler |
| trig_pulse | output | 1 | One-cycle special event or rollover trigger |

## Verification
Some properties are checked by assertions on every cycle:
- A disabled block is quiet.
- A fired one-shot holds its pin.
- A synchronised pin moves only on a rollover.
- Reserved clock codes freeze the count.
- The special event trigger follows each compare event.
- A 32-bit count steps by exactly one between matches.
- A postscaled interrupt never repeats on consecutive cycles.

Other properties can only be shown by the directed scenarios, because they depend on exact counts over long windows:
- Rollover spacing in both widths, including the carry past FFFFh.
- The single fire of a zero compare value across arm, retrigger and disarm.
- The postscaler ratio.
- Edge counting on each selectable source.

// File: rtl/ccomp_pkg.sv
`timescale 1ns/1ps
package ccomp_pkg;

    localparam int HALF_W     = 16;
    localparam int PS_W       = 4;
    localparam int ADDR_W     = 3;
    localparam int N_TICK_SRC = 5;

    typedef enum logic [2:0] {
        CS_CORE   = 3'b000,
        CS_RSV_A  = 3'b001,
        CS_SLOW   = 3'b010,
        CS_LOWPWR = 3'b011,
        CS_RSV_B  = 3'b100,
        CS_CELL   = 3'b101,
        CS_EXT_A  = 3'b110,
        CS_EXT_B  = 3'b111
    } clk_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_PER_L  = 3'd1,
        RA_PER_H  = 3'd2,
        RA_CMP_L  = 3'd3,
        RA_CMP_H  = 3'd4,
        RA_CNT_L  = 3'd5,
        RA_CNT_H  = 3'd6,
        RA_STROBE = 3'd7
    } reg_addr_e;

    // control word, LSB first: en, wide, csel, one_shot, sync_out, evt_sel, post, irq_on_cmp
    typedef struct packed {
        logic            irq_on_cmp;
        logic [PS_W-1:0] post;
        logic            evt_sel;
        logic            sync_out;
        logic            one_shot;
        clk_sel_e        csel;
        logic            wide;
        logic            en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // rise vector order: slow osc, low-power, logic cell, ext A, ext B
    function automatic logic pick_tick(clk_sel_e s, logic [N_TICK_SRC-1:0] rise);
        case (s)
            CS_CORE:   return 1'b1;
            CS_SLOW:   return rise[0];
            CS_LOWPWR: return rise[1];
            CS_CELL:   return rise[2];
            CS_EXT_A:  return rise[3];
            CS_EXT_B:  return rise[4];
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic is_reserved(clk_sel_e s);
        return (s == CS_RSV_A) || (s == CS_RSV_B);
    endfunction

endpackage

// File: rtl/ccomp_clk_pick.sv
`timescale 1ns/1ps
module ccomp_clk_pick
    import ccomp_pkg::*;
#(
    parameter int N_SRC = N_TICK_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  clk_sel_e         csel,
    output logic             tick
);

    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] rise;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) prev_q[g] <= 1'b0;
                else     prev_q[g] <= src_in[g];
            end
            assign rise[g] = src_in[g] & ~prev_q[g];
        end
    endgenerate

    always_comb tick = pick_tick(csel, rise);

endmodule

// File: rtl/ccomp_timebase.sv
`timescale 1ns/1ps
module ccomp_timebase #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    input  logic            wide,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [HW-1:0]   ld_val,
    input  logic [2*HW-1:0] per,
    output logic [2*HW-1:0] cnt,
    output logic            per_hit
);

    localparam int CW = 2 * HW;

    logic [CW-1:0] cnt_q;
    logic          match;
    logic          busy;
    logic [CW-1:0] step;

    always_comb begin
        match = wide ? (cnt_q == per) : (cnt_q[HW-1:0] == per[HW-1:0]);
        busy  = clr | ld_lo | ld_hi;
        step  = wide ? (cnt_q + CW'(1)) : {{HW{1'b0}}, cnt_q[HW-1:0] + HW'(1)};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt_q[HW-1:0]  <= ld_val;
            if (ld_hi) cnt_q[CW-1:HW] <= ld_val;
        end else if (run) begin
            cnt_q <= match ? '0 : step;
        end
    end

    assign cnt     = cnt_q;
    assign per_hit = run & match & ~busy;

    // R2: between matches a wide count only ever steps by one, even across FFFFh
    a_r2_wide_step: assert property (@(posedge clk) disable iff (rst)
        (!busy && run && wide && cnt_q != per) |=> cnt_q == $past(cnt_q) + CW'(1));

    // R1: a narrow match sends the count back to zero
    a_r1_narrow_wrap: assert property (@(posedge clk) disable iff (rst)
        (!busy && run && !wide && cnt_q[HW-1:0] == per[HW-1:0]) |=> cnt_q == '0);

endmodule

// File: rtl/ccomp_postscale.sv
`timescale 1ns/1ps
module ccomp_postscale #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          evt,
    input  logic [PW-1:0] div,
    output logic          pulse
);

    logic [PW-1:0] cnt_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (evt) begin
                if (cnt_q >= div) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + PW'(1);
                end
            end
        end
    end

    assign pulse = pulse_q;

    // R7: with a divide above one, two interrupts are never back to back
    a_r7_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (!clr && div != '0 && pulse_q) |=> !pulse_q);

endmodule

// File: rtl/ccomp_timer.sv
`timescale 1ns/1ps
module ccomp_timer
    import ccomp_pkg::*;
#(
    parameter int HALF_W_P = HALF_W,
    parameter int PS_W_P   = PS_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W_P-1:0] wr_data,
    input  logic                slow_osc_in,
    input  logic                lowpwr_in,
    input  logic                logic_cell_in,
    input  logic                ext_a_in,
    input  logic                ext_b_in,
    output logic                cmp_out,
    output logic                irq_pulse,
    output logic                trig_pulse
);

    localparam int CW = 2 * HALF_W_P;

    ctrl_t         ctrl_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] cmp_q;
    logic          armed_q, fired_q, pend_q, out_q, trig_q;

    reg_addr_e     addr;
    logic          trig_set, trig_clr;
    logic          ld_lo, ld_hi;
    logic          tick, run, tb_clr;
    logic [CW-1:0] cnt;
    logic          per_evt, cmp_match, cmp_evt, ps_evt;

    // register write port
    always_comb begin
        addr     = reg_addr_e'(wr_addr);
        trig_set = wr_en && addr == RA_STROBE && wr_data[0] && ctrl_q.one_shot;
        trig_clr = wr_en && addr == RA_STROBE && wr_data[1] && ctrl_q.one_shot;
        ld_lo    = wr_en && addr == RA_CNT_L;
        ld_hi    = wr_en && addr == RA_CNT_H && ctrl_q.wide;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            per_q  <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CTRL:  ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
                RA_PER_L: per_q[HALF_W_P-1:0]  <= wr_data;
                RA_PER_H: per_q[CW-1:HALF_W_P] <= wr_data;
                RA_CMP_L: cmp_q[HALF_W_P-1:0]  <= wr_data;
                RA_CMP_H: cmp_q[CW-1:HALF_W_P] <= wr_data;
                default: ;
            endcase
        end
    end

    // count enable selection
    ccomp_clk_pick #(.N_SRC(N_TICK_SRC)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .src_in ({ext_b_in, ext_a_in, logic_cell_in, lowpwr_in, slow_osc_in}),
        .csel   (ctrl_q.csel),
        .tick   (tick)
    );

    always_comb begin
        run    = ctrl_q.en & tick & (ctrl_q.one_shot ? armed_q : 1'b1);
        tb_clr = ~ctrl_q.en | trig_set | trig_clr;
    end

    ccomp_timebase #(.HW(HALF_W_P)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .clr     (tb_clr),
        .run     (run),
        .wide    (ctrl_q.wide),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_val  (wr_data),
        .per     (per_q),
        .cnt     (cnt),
        .per_hit (per_evt)
    );

    // compare stage
    always_comb begin
        cmp_match = ctrl_q.wide ? (cnt == cmp_q)
                                : (cnt[HALF_W_P-1:0] == cmp_q[HALF_W_P-1:0]);
        cmp_evt   = run & cmp_match & ~tb_clr & ~ld_lo & ~ld_hi
                    & ~(ctrl_q.one_shot & fired_q);
        ps_evt    = ctrl_q.irq_on_cmp ? cmp_evt : per_evt;
    end

    // one-shot arming
    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.en) begin
            armed_q <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            if (trig_clr)       armed_q <= 1'b0;
            else if (trig_set)  armed_q <= 1'b1;
            else if (per_evt)   armed_q <= 1'b0;

            if (trig_set || trig_clr) fired_q <= 1'b0;
            else if (cmp_evt)         fired_q <= 1'b1;
        end
    end

    // output pin, direct or held to the next rollover
    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.en) begin
            out_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (ctrl_q.sync_out) begin
            if (per_evt) begin
                if (pend_q || cmp_evt) out_q <= ~out_q;
                pend_q <= 1'b0;
            end else if (trig_clr) begin
                pend_q <= 1'b0;
            end else if (cmp_evt) begin
                pend_q <= 1'b1;
            end
        end else begin
            pend_q <= 1'b0;
            if (cmp_evt) out_q <= ~out_q;
        end
    end

    // trigger output
    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= ctrl_q.en & (ctrl_q.evt_sel ? cmp_evt : per_evt);
    end

    ccomp_postscale #(.PW(PS_W_P)) u_ps (
        .clk   (clk),
        .rst   (rst),
        .clr   (~ctrl_q.en),
        .evt   (ps_evt),
        .div   (ctrl_q.post),
        .pulse (irq_pulse)
    );

    assign cmp_out    = out_q;
    assign trig_pulse = trig_q;

    // R9: a disabled block holds count at zero, pin low, interrupt quiet
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |=> (cnt == '0 && !cmp_out && !irq_pulse));

    // R6: special event trigger follows every compare event
    a_r6_evt_each_match: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && ctrl_q.evt_sel && cmp_evt) |=> trig_pulse);

    // R3: a fired one-shot leaves the pin alone until software acts
    a_r3_fired_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && ctrl_q.one_shot && fired_q && !ctrl_q.sync_out && !wr_en)
        |=> $stable(cmp_out));

    // R5: a synchronised pin moves only on a rollover cycle
    a_r5_sync_aligned: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && ctrl_q.sync_out && !per_evt && !wr_en) |=> $stable(cmp_out));

    // R8: reserved select codes never advance the count
    a_r8_reserved_frozen: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && is_reserved(ctrl_q.csel) && !wr_en) |=> $stable(cnt));

endmodule

// File: tb/ccomp_timer_tb_top.sv
`timescale 1ns/1ps
module ccomp_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  src_v = '0;   // slow, lowpwr, cell, ext A, ext B
    logic        cmp_out, irq_pulse, trig_pulse;

    int total = 0;
    int bad   = 0;
    int n_irq, n_trig, n_tog, n_tog_irq;

    always #4 clk = ~clk;

    ccomp_timer dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .slow_osc_in   (src_v[0]),
        .lowpwr_in     (src_v[1]),
        .logic_cell_in (src_v[2]),
        .ext_a_in      (src_v[3]),
        .ext_b_in      (src_v[4]),
        .cmp_out       (cmp_out),
        .irq_pulse     (irq_pulse),
        .trig_pulse    (trig_pulse)
    );

    function automatic logic [15:0] mk(bit en, bit wide, bit [2:0] cs, bit os, bit sy,
                                       bit ev, bit [3:0] ps, bit ic);
        return {3'b000, ic, ps, ev, sy, os, cs, wide, en};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // observe n cycles; mode 0 idle, 1 hold source high, 2 alternate source
    task automatic run(input int n, input int mode = 0, input int src = 0);
        logic prev;
        prev = cmp_out;
        n_irq = 0; n_trig = 0; n_tog = 0; n_tog_irq = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_pulse)  n_irq++;
            if (trig_pulse) n_trig++;
            if (cmp_out != prev) begin
                n_tog++;
                if (irq_pulse) n_tog_irq++;
            end
            prev = cmp_out;
            if (mode == 1) src_v[src] = 1'b1;
            if (mode == 2) src_v[src] = (i % 2 == 0);
        end
        src_v = '0;
    endtask

    task automatic setup(input logic [31:0] per, input logic [31:0] cmp);
        wr(3'd0, 16'h0000);
        run(2);
        wr(3'd1, per[15:0]);  wr(3'd2, per[31:16]);
        wr(3'd3, cmp[15:0]);  wr(3'd4, cmp[31:16]);
    endtask

    task automatic t_reset;
        chk("R9 reset pin", cmp_out, 0);
        chk("R9 reset irq", irq_pulse, 0);
        chk("R9 reset trig", trig_pulse, 0);
    endtask

    task automatic t_narrow;
        setup(32'd9, 32'd3);
        wr(3'd0, mk(1, 0, 3'b000, 0, 0, 0, 4'd0, 0));
        run(100);
        chk("R1 rollover count", n_irq, 10);
        chk("R6 trig on rollover", n_trig, 10);
        chk("R10 toggles", n_tog, 10);
        chk("R10 toggles off rollover", n_tog_irq, 0);
    endtask

    task automatic t_wide;
        // high half equal to high period, low half above low period
        setup(32'h0000_0005, 32'hFFFF_FFFF);
        wr(3'd0, mk(1, 1, 3'b001, 0, 0, 0, 4'd0, 0));
        wr(3'd5, 16'hFFF0); wr(3'd6, 16'h0000);
        wr(3'd0, mk(1, 1, 3'b000, 0, 0, 0, 4'd0, 0));
        run(40);
        chk("R2 no rollover on low wrap", n_irq, 0);
        // period beyond the low wrap
        setup(32'h0001_0008, 32'hFFFF_FFFF);
        wr(3'd0, mk(1, 1, 3'b001, 0, 0, 0, 4'd0, 0));
        wr(3'd5, 16'hFFF0); wr(3'd6, 16'h0000);
        run(10);
        chk("R8 reserved 001 no count", n_irq, 0);
        wr(3'd0, mk(1, 1, 3'b000, 0, 0, 0, 4'd0, 0));
        run(20);
        chk("R2 none before full match", n_irq, 0);
        run(20);
        chk("R2 one at full match R11", n_irq, 1);
    endtask

    task automatic t_oneshot;
        setup(32'd20, 32'd0);
        wr(3'd0, mk(1, 0, 3'b000, 1, 0, 0, 4'd0, 1));
        run(30);
        chk("R3 idle no toggle", n_tog, 0);
        wr(3'd7, 16'h0001);
        run(60);
        chk("R3 one toggle cmp zero", n_tog, 1);
        chk("R3 one irq", n_irq, 1);
        wr(3'd7, 16'h0002);
        run(30);
        chk("R3 after clear no event", n_tog, 0);
        wr(3'd7, 16'h0001);
        run(60);
        chk("R3 rearm fires once", n_tog, 1);
    endtask

    task automatic t_retrig;
        setup(32'd30, 32'd0);
        wr(3'd0, mk(1, 0, 3'b000, 1, 0, 0, 4'd0, 1));
        wr(3'd7, 16'h0001);
        run(5);
        chk("R4 first arm", n_tog, 1);
        wr(3'd7, 16'h0001);
        run(5);
        chk("R4 retrigger fires again", n_tog, 1);
        wr(3'd3, 16'd10);
        wr(3'd7, 16'h0001);
        run(5);
        chk("R4 restart before match", n_tog, 0);
        wr(3'd7, 16'h0003);
        run(40);
        chk("R4 clear wins, no fire", n_tog, 0);
    endtask

    task automatic t_sync;
        setup(32'd9, 32'd3);
        wr(3'd0, mk(1, 0, 3'b000, 0, 1, 0, 4'd0, 0));
        run(100);
        chk("R5 toggles from first period", n_tog, 10);
        chk("R5 toggles on rollover", n_tog_irq, 10);
    endtask

    task automatic t_post;
        setup(32'd9, 32'd3);
        wr(3'd0, mk(1, 0, 3'b000, 0, 0, 1, 4'd3, 1));
        run(100);
        chk("R6 trig every match", n_trig, 10);
        chk("R7 postscale by four", n_irq, 2);
    endtask

    task automatic t_csel;
        setup(32'd0, 32'hFFFF);
        wr(3'd0, mk(1, 0, 3'b010, 0, 0, 0, 4'd0, 0));
        run(20, 1, 0);
        chk("R8 held level one edge", n_irq, 1);
        run(20, 2, 0);
        chk("R8 slow osc edges", n_irq, 10);
        wr(3'd0, mk(1, 0, 3'b111, 0, 0, 0, 4'd0, 0));
        run(12, 2, 4);
        chk("R8 ext B edges", n_irq, 6);
        wr(3'd0, mk(1, 0, 3'b100, 0, 0, 0, 4'd0, 0));
        run(12, 2, 3);
        chk("R8 reserved 100", n_irq, 0);
    endtask

    task automatic t_disable;
        setup(32'd9, 32'd3);
        wr(3'd0, mk(1, 0, 3'b000, 0, 0, 0, 4'd0, 0));
        run(5);
        chk("R10 pin high after match", cmp_out, 1);
        wr(3'd0, mk(0, 0, 3'b000, 0, 0, 0, 4'd0, 0));
        run(1);
        chk("R9 pin low when off", cmp_out, 0);
        run(20);
        chk("R9 no irq when off", n_irq, 0);
        wr(3'd0, mk(1, 0, 3'b000, 0, 0, 0, 4'd0, 0));
        run(9);
        chk("R9 restart from zero early", n_irq, 0);
        run(1);
        chk("R9 restart from zero hit", n_irq, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_oneshot();
        t_retrig();
        t_sync();
        t_post();
        t_csel();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule